// File: doc/BRIEF.md
# Dual-Tone Sine Generator Channel Bank

This block produces one output sample stream per DAC channel. For each channel, the internal source is the sum of two numerically controlled sine tones. Each tone has three settings: a 16-bit tuning word, a 16-bit phase offset and a signed gain. A second source passes an externally streamed sample through instead. Software programs the tones through a simple word-addressed write/read port.

Tone settings are written into a staged copy, and the running generator keeps its active copy. A single global sync write copies every staged setting of every channel into the active set in one clock cycle. The same write reloads every phase accumulator with its phase offset, so all channels start their new waveforms coherently.

The sine values come from a table that is computed at elaboration. Each tone's table value is scaled by a sign-magnitude gain with 14 fractional bits. The two scaled tones are added, and the sum is saturated to the output width.

Top module: `dual_tone_dds`

## Requirements
- R1: A clock edge with `rstN` low clears all staged settings, all source selects, active gains, tuning words and accumulators. From that edge on, every `dacOut` lane is 0 and register reads of channel settings return 0.
- R2: Each channel c has a register block at byte address 0x400 + 0x40*c, holding five registers:
  - offset 0x00: tone A gain in bits 15:0;
  - offset 0x04: tone A tuning word in bits 15:0 and phase offset in bits 31:16;
  - offset 0x08: tone B gain;
  - offset 0x0C: tone B tuning word and phase offset;
  - offset 0x18: source select in bits 3:0.

  `rdData` returns the staged contents of `rdAddr` on the clock edge after the address is presented. Unimplemented bits read 0.
- R3: A written tuning word above 0x8000 (half the sample rate) is stored as 0x8000. Words up to and including 0x8000 are stored unchanged.
- R4: Writes of gain, tuning word or phase offset do not change `dacOut` until a sync write. A write to the sync register with bit 0 at 0 is not a sync.
- R5: A write to byte address 0x044 with bit 0 set is a self-clearing sync. On that edge, every channel's active gains and tuning words take the staged values and each tone accumulator loads its phase offset. The sample registered on the next edge uses the phase offset. Each following sample advances the accumulator by the tuning word, modulo 2^16.
- R6: Each tone contributes sin(2π·k/64)·32767·G, with tolerance for the table's approximation. Here k is accumulator bits 15:10, and G is the gain: bit 15 is the sign, bits 14:0 are the magnitude, and 0x4000 is unity. A channel's tone output is the sum of its two tones.
- R7: A tone sum beyond the output range saturates to 32767 or -32768.
- R8: Source select 0 outputs the tone sum and 2 outputs `extSample` with one cycle of latency. Any other value outputs 0. A source select write takes effect without a sync.
- R9: Byte address 0x00C reads bit 0 as 1 when the tone generator is built out (`DDS_EN`=0) and 0 otherwise. When it is built out, the tone source outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample and register clock |
| rstN | input | 1 | Synchronous active-low core reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W | Register write byte address |
| wrData | input | 32 | Register write data |
| rdAddr | input | ADDR_W | Register read byte address |
| rdData | output | 32 | Registered read data |
| extSample | input | NCH*SMP_W | Streamed external samples, channel c in lane c |
| dacOut | output | NCH*SMP_W | Output samples, channel c in lane c |

## Verification
Zero tuning words with random phase offsets and random signed gains give static tone sums. These are compared with a real-valued sine model, which separates gain sign, magnitude scaling and table addressing errors. A nonzero tuning word on two channels at different phase offsets shows the accumulator step and that both channels restart on the same edge. Full-scale gains at peak phase separate correct saturation from wrap-around. Streamed random values, together with a reserved select code, separate the source-mux paths and the one-cycle latency. Writes without a sync, and syncs with bit 0 clear, show that staging holds the output still.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int TONES = 2;
  localparam int GAIN_FRAC = 14;
  localparam logic [15:0] FREQ_LIMIT = 16'h8000;
  localparam logic [3:0] SRC_TONE = 4'd0;
  localparam logic [3:0] SRC_EXT = 4'd2;

  typedef struct packed {
    logic [15:0] gain;
    logic [15:0] phase;
    logic [15:0] freq;
  } toneCfg_t;

  typedef struct packed {
    logic syncLoad;
  } ctrlStrobe_t;

  function automatic logic [15:0] clampFreq(logic [15:0] w);
    return (w > FREQ_LIMIT) ? FREQ_LIMIT : w;
  endfunction

  // Rational half-wave sine approximation, amplitude 32767.
  function automatic logic [15:0] sineEntry(int idx, int aw);
    longint n, i, u, v;
    n = longint'(1) << (aw - 1);
    i = longint'(idx) % n;
    u = i * (n - i);
    v = (longint'(32767) * 16 * u) / (5 * n * n - 4 * u);
    if (longint'(idx) >= n) v = -v;
    return 16'(v);
  endfunction
endpackage

// File: rtl/dtg_ctrl.sv
module dtg_ctrl
  import dtg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter int DDS_EN = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0] rdData,
  output ctrlStrobe_t strobe,
  output toneCfg_t [NCH-1:0][TONES-1:0] staged,
  output logic [NCH-1:0][3:0] srcSel
);
  localparam logic [ADDR_W-1:0] SYNC_ADDR = ADDR_W'(12'h044);
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-11:0] CH_SPACE = (ADDR_W-10)'(1);

  logic wrHit, rdHit;
  logic [31:0] rdNext;

  assign wrHit = wrEn && (wrAddr[ADDR_W-1:10] == CH_SPACE);
  assign rdHit = (rdAddr[ADDR_W-1:10] == CH_SPACE);
  assign strobe.syncLoad = wrEn && (wrAddr == SYNC_ADDR) && wrData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      staged <= '0;
      srcSel <= '0;
    end else if (wrHit) begin
      for (int c = 0; c < NCH; c++) begin
        if (wrAddr[9:6] == 4'(c)) begin
          case (wrAddr[5:0])
            6'h00: staged[c][0].gain <= wrData[15:0];
            6'h04: begin
              staged[c][0].freq  <= clampFreq(wrData[15:0]);
              staged[c][0].phase <= wrData[31:16];
            end
            6'h08: staged[c][1].gain <= wrData[15:0];
            6'h0C: begin
              staged[c][1].freq  <= clampFreq(wrData[15:0]);
              staged[c][1].phase <= wrData[31:16];
            end
            6'h18: srcSel[c] <= wrData[3:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (rdAddr == CFG_ADDR) begin
      rdNext[0] = (DDS_EN == 0);
    end else if (rdHit) begin
      for (int c = 0; c < NCH; c++) begin
        if (rdAddr[9:6] == 4'(c)) begin
          case (rdAddr[5:0])
            6'h00: rdNext = {16'h0, staged[c][0].gain};
            6'h04: rdNext = {staged[c][0].phase, staged[c][0].freq};
            6'h08: rdNext = {16'h0, staged[c][1].gain};
            6'h0C: rdNext = {staged[c][1].phase, staged[c][1].freq};
            6'h18: rdNext = {28'h0, srcSel[c]};
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end
endmodule

// File: rtl/dtg_datapath.sv
module dtg_datapath
  import dtg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int LUT_AW = 6,
  parameter int SMP_W = 16,
  parameter int DDS_EN = 1
) (
  input  logic clk,
  input  logic rstN,
  input  ctrlStrobe_t strobe,
  input  toneCfg_t [NCH-1:0][TONES-1:0] staged,
  input  logic [NCH-1:0][3:0] srcSel,
  input  logic [NCH*SMP_W-1:0] extSample,
  output logic [NCH*SMP_W-1:0] dacOut
);
  localparam int LUT_N = 1 << LUT_AW;
  localparam int SUM_W = 20;
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic signed [15:0] sineLut [LUT_N];
  logic [NCH-1:0][TONES-1:0][15:0] acc;
  logic [NCH-1:0][TONES-1:0][15:0] actGain;
  logic [NCH-1:0][TONES-1:0][15:0] actFreq;

  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    assign sineLut[i] = sineEntry(i, LUT_AW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc     <= '0;
      actGain <= '0;
      actFreq <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        for (int t = 0; t < TONES; t++) begin
          if (strobe.syncLoad) begin
            actGain[c][t] <= staged[c][t].gain;
            actFreq[c][t] <= staged[c][t].freq;
            acc[c][t]     <= staged[c][t].phase;
          end else begin
            acc[c][t] <= acc[c][t] + actFreq[c][t];
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [SUM_W-1:0] toneVal [TONES];
    logic signed [SUM_W-1:0] sumVal;
    logic [SMP_W-1:0] satVal, nextOut, outQ;

    for (genvar t = 0; t < TONES; t++) begin : g_tone
      logic signed [15:0] sineVal;
      logic signed [32:0] prod, scaled;
      assign sineVal = sineLut[acc[c][t][15 -: LUT_AW]];
      assign prod = sineVal * $signed({1'b0, actGain[c][t][14:0]});
      assign scaled = prod >>> GAIN_FRAC;
      assign toneVal[t] = actGain[c][t][15] ? -SUM_W'(scaled) : SUM_W'(scaled);
    end

    if (DDS_EN != 0) begin : g_dds
      assign sumVal = toneVal[0] + toneVal[1];
    end else begin : g_nodds
      assign sumVal = '0;
    end

    always_comb begin
      if (sumVal > SAT_HI)      satVal = SMP_W'(SAT_HI);
      else if (sumVal < SAT_LO) satVal = SMP_W'(SAT_LO);
      else                      satVal = SMP_W'(sumVal);
      case (srcSel[c])
        SRC_TONE: nextOut = satVal;
        SRC_EXT:  nextOut = extSample[c*SMP_W +: SMP_W];
        default:  nextOut = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) outQ <= '0;
      else       outQ <= nextOut;
    end

    assign dacOut[c*SMP_W +: SMP_W] = outQ;
  end
endmodule

// File: rtl/dual_tone_dds.sv
module dual_tone_dds
  import dtg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter int LUT_AW = 6,
  parameter int SMP_W = 16,
  parameter int DDS_EN = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0] rdData,
  input  logic [NCH*SMP_W-1:0] extSample,
  output logic [NCH*SMP_W-1:0] dacOut
);
  ctrlStrobe_t strobe;
  toneCfg_t [NCH-1:0][TONES-1:0] staged;
  logic [NCH-1:0][3:0] srcSel;

  dtg_ctrl #(.NCH(NCH), .ADDR_W(ADDR_W), .DDS_EN(DDS_EN)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strobe(strobe), .staged(staged),
    .srcSel(srcSel)
  );

  dtg_datapath #(.NCH(NCH), .LUT_AW(LUT_AW), .SMP_W(SMP_W), .DDS_EN(DDS_EN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .staged(staged), .srcSel(srcSel),
    .extSample(extSample), .dacOut(dacOut)
  );
endmodule

// File: rtl/dual_tone_dds_checker.sv
module dual_tone_dds_checker
  import dtg_pkg::*;
#(
  parameter int NCH = 2,
  parameter int ADDR_W = 12,
  parameter int SMP_W = 16,
  parameter int DDS_EN = 1
) (
  input logic clk,
  input logic rstN,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [31:0] rdData,
  input logic [SMP_W-1:0] ext0,
  input logic [NCH*SMP_W-1:0] dacOut,
  input logic [3:0] sel0,
  input logic [15:0] freqA0,
  input logic [15:0] freqB0
);
  logic rstWasLow = 1'b0;

  always_ff @(posedge clk) rstWasLow <= !rstN;

  // R1: an edge with reset low leaves every lane at zero
  always @(posedge clk) begin
    if (rstWasLow) p_reset_zero_r1: assert (dacOut == '0);
  end

  p_freq_limit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (freqA0 <= FREQ_LIMIT) && (freqB0 <= FREQ_LIMIT));

  p_ext_pass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sel0 == SRC_EXT) |=> (dacOut[SMP_W-1:0] == $past(ext0)));

  p_bad_sel_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sel0 != SRC_EXT && sel0 != SRC_TONE) |=> (dacOut[SMP_W-1:0] == '0));

  p_cfg_read_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == ADDR_W'(12'h00C)) |=> (rdData == {31'b0, (DDS_EN == 0)}));
endmodule

bind dual_tone_dds dual_tone_dds_checker #(
  .NCH(NCH), .ADDR_W(ADDR_W), .SMP_W(SMP_W), .DDS_EN(DDS_EN)
) u_chk (
  .clk(clk), .rstN(rstN), .rdAddr(rdAddr), .rdData(rdData),
  .ext0(extSample[SMP_W-1:0]), .dacOut(dacOut), .sel0(srcSel[0]),
  .freqA0(staged[0][0].freq), .freqB0(staged[0][1].freq)
);

// File: tb/dual_tone_dds_tb.sv
module dual_tone_dds_tb;
  localparam int NCH = 2;
  localparam int SW = 16;
  localparam int TOL = 240;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [11:0] wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic [NCH*SW-1:0] extSample = '0;
  logic [NCH*SW-1:0] dacOut;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_tone_dds u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .extSample(extSample), .dacOut(dacOut)
  );

  function automatic logic [11:0] chReg(int c, int off);
    return 12'(12'h400 + 12'h40 * c + off);
  endfunction

  function automatic real toneModel(logic [15:0] accv, logic [15:0] g);
    real s, m;
    s = $sin(2.0 * PI * real'(accv >> 10) / 64.0) * 32767.0;
    m = real'(g[14:0]) / 16384.0;
    return g[15] ? -s * m : s * m;
  endfunction

  function automatic int expSum(logic [15:0] a0, logic [15:0] g0,
                                logic [15:0] a1, logic [15:0] g1);
    real r;
    int v;
    r = toneModel(a0, g0) + toneModel(a1, g1);
    v = $rtoi(r);
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    return v;
  endfunction

  function automatic int lane(int c);
    return int'($signed(dacOut[c*SW +: SW]));
  endfunction

  task automatic checkEq(string tag, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkNear(string tag, int act, int exp);
    int d;
    nChecks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > TOL) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic regWrite(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    @(negedge clk);
    d = rdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] g [NCH][2];
    logic [15:0] ph [NCH][2];
    logic [15:0] prevExt;
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    checkEq("R1 reset lane0", lane(0), 0);
    checkEq("R1 reset lane1", lane(1), 0);
    rstN = 1'b1;
    regRead(chReg(0, 'h00), rd);
    checkEq("R1 staged gain after reset", rd, 0);
    regRead(chReg(1, 'h18), rd);
    checkEq("R1 source select after reset", rd, 0);

    regRead(12'h00C, rd);
    checkEq("R9 config bit", rd, 0);

    regWrite(chReg(1, 'h0C), 32'h1234_0567);
    regRead(chReg(1, 'h0C), rd);
    checkEq("R2 freq/phase readback", rd, 32'h1234_0567);
    regWrite(chReg(1, 'h18), 32'hFFFF_FFF5);
    regRead(chReg(1, 'h18), rd);
    checkEq("R2 select readback unused bits", rd, 5);
    regWrite(chReg(1, 'h08), 32'hABCD_9001);
    regRead(chReg(1, 'h08), rd);
    checkEq("R2 gain readback", rd, 32'h0000_9001);
    regWrite(chReg(1, 'h18), 32'h0);

    regWrite(chReg(0, 'h04), 32'h0000_C000);
    regRead(chReg(0, 'h04), rd);
    checkEq("R3 clamp above limit", rd, 32'h0000_8000);
    regWrite(chReg(0, 'h04), 32'h0000_8000);
    regRead(chReg(0, 'h04), rd);
    checkEq("R3 limit kept", rd, 32'h0000_8000);
    regWrite(chReg(0, 'h04), 32'h0000_7FFF);
    regRead(chReg(0, 'h04), rd);
    checkEq("R3 below limit kept", rd, 32'h0000_7FFF);

    // R4: staged writes do not reach the output without a sync
    regWrite(chReg(0, 'h00), 32'h4000);
    regWrite(chReg(0, 'h04), 32'h4000_0000);
    regWrite(chReg(0, 'h08), 32'h0);
    regWrite(chReg(1, 'h08), 32'h0);
    repeat (3) @(negedge clk);
    checkEq("R4 no sync lane0", lane(0), 0);
    regWrite(12'h044, 32'h0);
    repeat (3) @(negedge clk);
    checkEq("R4 sync bit clear lane0", lane(0), 0);
    regWrite(12'h044, 32'h1);
    @(negedge clk);
    checkNear("R5 first sample after sync", lane(0), expSum(16'h4000, 16'h4000, 16'h0, 16'h0));

    // R6: random static tones
    for (int it = 0; it < 40; it++) begin
      for (int c = 0; c < NCH; c++) begin
        for (int t = 0; t < 2; t++) begin
          g[c][t] = 16'($urandom);
          ph[c][t] = 16'($urandom);
          regWrite(chReg(c, t * 8), {16'h0, g[c][t]});
          regWrite(chReg(c, t * 8 + 4), {ph[c][t], 16'h0});
        end
      end
      regWrite(12'h044, 32'h1);
      @(negedge clk);
      for (int c = 0; c < NCH; c++)
        checkNear("R6 random tone sum", lane(c),
                  expSum(ph[c][0], g[c][0], ph[c][1], g[c][1]));
    end

    // R7: saturation both directions
    regWrite(chReg(0, 'h00), 32'h7FFF);
    regWrite(chReg(0, 'h04), 32'h4000_0000);
    regWrite(chReg(0, 'h08), 32'h7FFF);
    regWrite(chReg(0, 'h0C), 32'h4000_0000);
    regWrite(12'h044, 32'h1);
    @(negedge clk);
    checkEq("R7 positive saturation", lane(0), 32767);
    regWrite(chReg(0, 'h00), 32'hFFFF);
    regWrite(chReg(0, 'h08), 32'hFFFF);
    regWrite(12'h044, 32'h1);
    @(negedge clk);
    checkEq("R7 negative saturation", lane(0), -32768);

    // R5: stepping accumulators, both channels restarted together
    regWrite(chReg(0, 'h00), 32'h4000);
    regWrite(chReg(0, 'h04), 32'h0000_0400);
    regWrite(chReg(0, 'h08), 32'h0);
    regWrite(chReg(1, 'h00), 32'h2000);
    regWrite(chReg(1, 'h04), 32'h8000_0400);
    regWrite(chReg(1, 'h08), 32'h0);
    regWrite(12'h044, 32'h1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      checkNear("R5 step lane0", lane(0),
                expSum(16'(k * 16'h400), 16'h4000, 16'h0, 16'h0));
      checkNear("R5 step lane1", lane(1),
                expSum(16'(16'h8000 + k * 16'h400), 16'h2000, 16'h0, 16'h0));
    end

    // R8: external source and reserved select code
    regWrite(chReg(0, 'h18), 32'h2);
    prevExt = '0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (k > 1) checkEq("R8 external passthrough", dacOut[SW-1:0], prevExt);
      prevExt = 16'($urandom);
      extSample[SW-1:0] = prevExt;
    end
    regWrite(chReg(0, 'h18), 32'h7);
    @(negedge clk);
    checkEq("R8 reserved select", lane(0), 0);
    regWrite(chReg(0, 'h18), 32'h0);
    @(negedge clk);
    @(negedge clk);
    checkEq("R8 back to tones nonzero", (lane(0) != 0), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule